// File: doc/BRIEF.md
# Multi-Bank SRAM Zero-Fill Sequencer

This block clears selected SRAM banks to all-zero words, with valid parity, when software asks for it. Software picks the banks with a bitmap register and then sets a start bit. Every chosen bank is swept in parallel, one word per clock per bank, from address zero to its last word. A per-bank activity vector shows which banks are still being swept. The start bit clears itself once every chosen bank has finished, and a one-cycle completion pulse marks that moment. A configuration bit must be set to unlock the start bit, so a stray write cannot start a sweep.

Each bank has its own write port carrying an enable, an address, a data word and a parity bit. While a bank is idle, its port passes the functional write request through. While a bank is being swept, the sequencer owns the port and the functional side is told to hold off. Bank n holds `BASE_DEPTH + n*DEPTH_STEP` words.

Top module: `bank_zero_seq`

## Requirements
- R1: After reset the config, select, start and activity registers all read 0, `done_o` is low and every bank reports ready.
- R2: The register port decodes 2-bit offsets as follows. Offset 0 is config, with bit 0 as unlock. Offset 1 is select, with bit n choosing bank n. Offset 2 is start (bit 0). Offset 3 is the read-only activity vector, with bit n for bank n. Unused read bits return 0.
- R3: A write of 1 to start bit 0 takes effect only while unlock is 1. Otherwise the start bit stays 0 and no bank begins a sweep.
- R4: An accepted start makes every selected bank write in the following cycles. It writes address k in the k-th cycle after the start edge, for k from 0 to its depth-1, with data 0 and parity bit 1, using odd parity over data plus parity bit.
- R5: The activity bit of bank n is high for exactly depth(n) cycles after the start edge, and it drops without waiting for the other banks.
- R6: In the first cycle in which no bank is active while start is still 1, `done_o` is high for that one cycle. Start reads 0 from the next cycle on.
- R7: Writes to select during a sweep do not change which banks are swept. A write to start while start is still 1 has no effect.
- R8: A start with an empty selection raises `done_o` in the cycle right after the start edge and produces no sequencer writes. Start reads 0 one cycle later.
- R9: While bank n is active, `func_ready_o[n]` is 0 and its functional request is not forwarded. While bank n is idle, `func_ready_o[n]` is 1 and its enable, address and data pass to the bank port, with an odd-parity bit computed over the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data (combinational) |
| func_we_i | input | NUM_BANKS | Functional write enable per bank |
| func_addr_i | input | NUM_BANKS*ADDR_W | Functional address per bank |
| func_wdata_i | input | NUM_BANKS*DATA_W | Functional data per bank |
| func_ready_o | output | NUM_BANKS | Bank accepts functional traffic |
| mem_we_o | output | NUM_BANKS | Bank write enable |
| mem_addr_o | output | NUM_BANKS*ADDR_W | Bank write address |
| mem_wdata_o | output | NUM_BANKS*DATA_W | Bank write data |
| mem_par_o | output | NUM_BANKS | Bank parity bit |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
If a bank's address counter is corrupted, the bank port shows a wrong address in the very next write cycle. If a counter is stuck, the bank's ready signal comes back one or more cycles away from depth(n). A bad activity snapshot shows up in the first cycle after the start edge as a write on an unselected bank, or a forwarded functional request on a selected one. A start bit that clears too early or too late moves `done_o` off the cycle that follows the longest selected bank.

// File: rtl/bank_zero_pkg.sv
package bank_zero_pkg;
  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_SEL  = 2'd1,
    REG_TRIG = 2'd2,
    REG_BUSY = 2'd3
  } reg_addr_e;

  function automatic int unsigned bank_depth(int unsigned base, int unsigned step,
                                             int unsigned idx);
    return base + idx * step;
  endfunction
endpackage

// File: rtl/bzs_ctrl_regs.sv
module bzs_ctrl_regs import bank_zero_pkg::*; #(
  parameter int unsigned NUM_BANKS = 7,
  parameter int unsigned REG_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  input  logic [NUM_BANKS-1:0] busy_i,
  output logic [NUM_BANKS-1:0] sel_o,
  output logic                 start_o,
  output logic                 done_o
);
  logic                 unlock_q, trig_q;
  logic [NUM_BANKS-1:0] sel_q;
  logic                 wr_cfg, wr_sel, wr_trig;
  logic                 unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign wr_cfg  = reg_we_i && (reg_addr_i == REG_CFG);
  assign wr_sel  = reg_we_i && (reg_addr_i == REG_SEL);
  assign wr_trig = reg_we_i && (reg_addr_i == REG_TRIG);

  // start is accepted only when unlocked and idle
  assign start_o = wr_trig && reg_wdata_i[0] && unlock_q && !trig_q;
  assign done_o  = trig_q && (busy_i == '0);
  assign sel_o   = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      sel_q    <= '0;
      trig_q   <= 1'b0;
    end else begin
      if (wr_cfg) unlock_q <= reg_wdata_i[0];
      if (wr_sel) sel_q    <= reg_wdata_i[NUM_BANKS-1:0];
      if (start_o)     trig_q <= 1'b1;
      else if (done_o) trig_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CFG:  reg_rdata_o[0]           = unlock_q;
      REG_SEL:  reg_rdata_o[NUM_BANKS-1:0] = sel_q;
      REG_TRIG: reg_rdata_o[0]           = trig_q;
      REG_BUSY: reg_rdata_o[NUM_BANKS-1:0] = busy_i;
      default:  reg_rdata_o = '0;
    endcase
  end

  p_trig_clears_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trig_q) |-> $past(busy_i) == '0);
  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_lock_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_trig && !unlock_q && !trig_q) |=> !trig_q);
  p_busy_needs_trig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i != '0) |-> trig_q);
endmodule

// File: rtl/bzs_bank_walker.sv
module bzs_bank_walker #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 32,
  parameter bit          ODD_PAR = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sel_i,
  input  logic              func_we_i,
  input  logic [ADDR_W-1:0] func_addr_i,
  input  logic [DATA_W-1:0] func_wdata_i,
  output logic              busy_o,
  output logic              func_ready_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_par_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic              busy_q;
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && sel_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (busy_q) begin
      mem_we_o    = 1'b1;
      mem_addr_o  = cnt_q;
      mem_wdata_o = '0;
    end else begin
      mem_we_o    = func_we_i;
      mem_addr_o  = func_addr_i;
      mem_wdata_o = func_wdata_i;
    end
  end

  assign mem_par_o    = (^mem_wdata_o) ^ ODD_PAR;
  assign func_ready_o = !busy_q;
  assign busy_o       = busy_q;

  p_ends_at_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == LAST);
  p_starts_on_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i && sel_i));
  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> cnt_q == $past(cnt_q) + 1'b1);
  p_owns_port_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (mem_we_o && mem_wdata_o == '0 && !func_ready_o));
endmodule

// File: rtl/bank_zero_seq.sv
module bank_zero_seq import bank_zero_pkg::*; #(
  parameter int unsigned NUM_BANKS  = 7,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned BASE_DEPTH = 8,
  parameter int unsigned DEPTH_STEP = 4,
  parameter int unsigned REG_W      = 8,
  localparam int unsigned MAX_DEPTH = BASE_DEPTH + (NUM_BANKS - 1) * DEPTH_STEP,
  localparam int unsigned ADDR_W    = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_we_i,
  input  logic [1:0]                    reg_addr_i,
  input  logic [REG_W-1:0]              reg_wdata_i,
  output logic [REG_W-1:0]              reg_rdata_o,
  input  logic [NUM_BANKS-1:0]          func_we_i,
  input  logic [NUM_BANKS*ADDR_W-1:0]   func_addr_i,
  input  logic [NUM_BANKS*DATA_W-1:0]   func_wdata_i,
  output logic [NUM_BANKS-1:0]          func_ready_o,
  output logic [NUM_BANKS-1:0]          mem_we_o,
  output logic [NUM_BANKS*ADDR_W-1:0]   mem_addr_o,
  output logic [NUM_BANKS*DATA_W-1:0]   mem_wdata_o,
  output logic [NUM_BANKS-1:0]          mem_par_o,
  output logic                          done_o
);
  logic [NUM_BANKS-1:0] busy, sel;
  logic                 start;

  bzs_ctrl_regs #(.NUM_BANKS(NUM_BANKS), .REG_W(REG_W)) i_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .sel_o(sel), .start_o(start), .done_o
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bzs_bank_walker #(
      .DEPTH  (bank_depth(BASE_DEPTH, DEPTH_STEP, b)),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .ODD_PAR(1'b1)
    ) i_walker (
      .clk_i, .rst_ni,
      .start_i     (start),
      .sel_i       (sel[b]),
      .func_we_i   (func_we_i[b]),
      .func_addr_i (func_addr_i[b*ADDR_W +: ADDR_W]),
      .func_wdata_i(func_wdata_i[b*DATA_W +: DATA_W]),
      .busy_o      (busy[b]),
      .func_ready_o(func_ready_o[b]),
      .mem_we_o    (mem_we_o[b]),
      .mem_addr_o  (mem_addr_o[b*ADDR_W +: ADDR_W]),
      .mem_wdata_o (mem_wdata_o[b*DATA_W +: DATA_W]),
      .mem_par_o   (mem_par_o[b])
    );
  end
endmodule

// File: tb/test_bank_zero_seq.sv
`timescale 1ns/1ps
module test_bank_zero_seq;
  localparam int NB = 7, DW = 32, AW = 5, RW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [RW-1:0] reg_wdata = '0, reg_rdata;
  logic [NB-1:0] func_we = '0, func_ready, mem_we, mem_par;
  logic [NB*AW-1:0] func_addr, mem_addr;
  logic [NB*DW-1:0] func_wdata, mem_wdata;
  logic done;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bank_zero_seq i_bank_zero_seq (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .func_we_i(func_we),
    .func_addr_i(func_addr), .func_wdata_i(func_wdata), .func_ready_o(func_ready),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_par_o(mem_par), .done_o(done)
  );

  function automatic int dep(int n); return 8 + 4 * n; endfunction
  function automatic logic [DW-1:0] fdat(int n); return 32'hC3A5_0000 + n * 32'h111; endfunction

  always_comb
    for (int n = 0; n < NB; n++) begin
      func_addr[n*AW +: AW]  = AW'(n + 3);
      func_wdata[n*DW +: DW] = fdat(n);
    end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [RW-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      chk(reg_rdata == '0, "R1", "reg after reset", reg_rdata, 0);
    end
    chk(func_ready == '1 && mem_we == '0 && !done, "R1", "ports after reset",
        {func_ready, mem_we, done}, {7'h7F, 7'h00, 1'b0});
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); reg_addr = 2'd3; #1;
    chk(reg_rdata == '0, "R1", "activity idle", reg_rdata, 0);
    reg_write(2'd1, 8'h55); reg_addr = 2'd1; #1;
    chk(reg_rdata == 8'h55, "R2", "select readback", reg_rdata, 8'h55);
    reg_write(2'd0, 8'hFF); reg_addr = 2'd0; #1;
    chk(reg_rdata == 8'h01, "R2", "config readback", reg_rdata, 8'h01);
  endtask

  task automatic t_lock;
    func_we = '0;
    reg_write(2'd0, 8'h00);
    reg_write(2'd1, 8'h7F);
    reg_write(2'd2, 8'h01);
    for (int k = 0; k < 3; k++) begin
      chk(reg_rdata[0] == 1'b0, "R3", "start while locked", reg_rdata, 0);
      chk(mem_we == '0 && func_ready == '1 && !done, "R3", "no sweep while locked",
          {mem_we, func_ready, done}, {7'h00, 7'h7F, 1'b0});
      @(negedge clk);
    end
  endtask

  task automatic t_run(input logic [NB-1:0] sel, input bit disturb, input logic fwe);
    int dmax = 0;
    string rq;
    for (int n = 0; n < NB; n++) if (sel[n] && dep(n) > dmax) dmax = dep(n);
    rq = (sel == '0) ? "R8" : "R6";
    func_we = {NB{fwe}};
    reg_write(2'd0, 8'h01);
    reg_write(2'd1, RW'(sel));
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
    @(negedge clk); reg_we = 1'b0; reg_addr = 2'd2;
    for (int k = 0; k <= dmax + 1; k++) begin
      for (int n = 0; n < NB; n++) begin
        if (sel[n] && k < dep(n)) begin
          chk(mem_we[n] && mem_addr[n*AW +: AW] == AW'(k) && mem_wdata[n*DW +: DW] == '0
              && mem_par[n], "R4", $sformatf("bank %0d zero write k=%0d", n, k),
              {mem_we[n], mem_par[n], mem_addr[n*AW +: AW]}, {2'b11, AW'(k)});
          chk(!func_ready[n], "R9", $sformatf("bank %0d held k=%0d", n, k), func_ready[n], 0);
        end else begin
          chk(func_ready[n], "R5", $sformatf("bank %0d idle k=%0d", n, k), func_ready[n], 1);
          chk(mem_we[n] == fwe && mem_addr[n*AW +: AW] == AW'(n + 3)
              && mem_wdata[n*DW +: DW] == fdat(n) && mem_par[n] == ~(^fdat(n)), "R9",
              $sformatf("bank %0d pass k=%0d", n, k), mem_wdata[n*DW +: DW], fdat(n));
        end
      end
      chk(done == (k == dmax), rq, $sformatf("done pulse k=%0d", k), done, k == dmax);
      if (!reg_we && reg_addr == 2'd2)
        chk(reg_rdata[0] == (k <= dmax), rq, $sformatf("start bit k=%0d", k),
            reg_rdata[0], k <= dmax);
      if (disturb) begin
        if (k == 1) begin reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = RW'(~sel); end
        if (k == 2) begin reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01; end  // R7
        if (k == 3) begin reg_we = 1'b0; reg_addr = 2'd2; end
      end
      @(negedge clk);
    end
    func_we = '0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_lock();
    t_run(7'b0000101, 1'b0, 1'b1);   // R4 R5 R6
    t_run(7'b1010011, 1'b1, 1'b1);   // R7 mid-run writes
    t_run(7'b0000000, 1'b0, 1'b0);   // R8 empty selection
    t_run(7'b1111111, 1'b0, 1'b0);   // R5 all banks
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule